// File: doc/BRIEF.md
# Eight-Channel Simultaneous-Sampling ADC Emulator

This block is a synthesizable stand-in for an eight-channel, 16-bit simultaneous-sampling converter. It is meant for testing a host-side controller without the real part. Everything runs on one model clock, and the host pins are sampled on that clock. Only the converter's handshake, timing and readout order are modelled. No analog behaviour is modelled.

A conversion begins when either of the two conversion-start inputs (one per group of four channels) returns high after being driven low. The busy flag then stays high for a span that grows with the oversampling setting. When busy falls, all eight sample registers are updated together with a counter-based test pattern.

The host reads the samples in one of two ways, selected by a mode pin:
- Parallel: it lowers chip select and pulses the read strobe once per channel, receiving the channels in ascending order.
- Serial: it lowers chip select and clocks two lanes at once. One lane carries channels 0 to 3 and the other carries channels 4 to 7.

Top module: `adc8_emulator`

## Requirements
- R1: A rising edge on `start_a_n` or on `start_b_n`, seen while no conversion runs and `dev_rst` is low, starts a conversion, and `busy` is high from the next clock cycle.
- R2: `busy` stays high for exactly BASE_CYCLES << `os_sel` clock cycles for `os_sel` 0 to 6, and for BASE_CYCLES cycles when `os_sel` is 7. The setting is captured in the cycle the conversion starts, so later changes to `os_sel` do not alter a running conversion.
- R3: A start edge that arrives while `busy` is high is ignored: the running conversion keeps its length and counts as one conversion only.
- R4: When `busy` falls after the k-th conversion since reset, all eight sample registers are updated in the same cycle. Channel c then holds c in bits 15:13 and k modulo 8192 in bits 12:0. Before the first conversion, every sample reads zero.
- R5: With `par_ser` low and `cs_n` low, each falling edge of `rd_n` places the next channel on `data_out` from the following clock cycle, in the order 0, 1, … 7.
- R6: Raising `cs_n` ends a parallel readout at any point and forces `data_out` to zero from the next cycle. The next readout starts again at channel 0.
- R7: With `par_ser` high, a falling edge of `cs_n` loads the lanes. `dout_a` carries channels 0, 1, 2, 3 and `dout_b` carries channels 4, 5, 6, 7, each sample MSB first. The first bit appears in the cycle after `cs_n` falls, and each falling edge of `sclk` advances both lanes by one bit.
- R8: The lanes drive zero while `cs_n` is high or `par_ser` is low, and `data_out` is zero while `par_ser` is high.
- R9: A high `dev_rst` aborts any conversion, so `busy` is low from the next cycle and stays low until a new start edge. It also clears the samples and the conversion count to zero and ends any readout.
- R10: After `rst_n` is released, `busy`, `data_out`, `dout_a` and `dout_b` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all host pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the model |
| dev_rst | input | 1 | Emulated converter reset pin, active high |
| start_a_n | input | 1 | Conversion start for channels 0–3; starts on return high |
| start_b_n | input | 1 | Conversion start for channels 4–7; starts on return high |
| os_sel | input | 3 | Oversampling setting; ratio 2^os_sel, value 7 treated as 0 |
| par_ser | input | 1 | Readout mode: 0 parallel bus, 1 serial lanes |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Parallel read strobe; falling edge advances the channel |
| sclk | input | 1 | Serial clock, idle high; falling edge advances the lanes |
| busy | output | 1 | High while a conversion is in progress |
| data_out | output | 16 | Parallel sample bus |
| dout_a | output | 1 | Serial lane for channels 0–3 |
| dout_b | output | 1 | Serial lane for channels 4–7 |

## Verification
The busy span is measured for every oversampling code, including the unused code 7. During each conversion `os_sel` is changed again, which separates a design that captures the setting at the start from one that keeps reading the pin. Start pulses that arrive inside a conversion check that a restart would both lengthen busy and skip a pattern count. Readouts alternate at random between full and truncated parallel reads and full serial reads. This exposes channel ordering, pointer restart after an early chip-select rise, lane pairing and bit order. A converter reset issued in the middle of a conversion shows whether busy aborts and the samples fall back to zero.

// File: rtl/adc8_pkg.sv
package adc8_pkg;

   typedef enum logic [0:0] {
      CONV_IDLE = 1'b0,
      CONV_RUN  = 1'b1
   } conv_state_e;

   // Number of busy cycles for one oversampling code; codes above os_max
   // fall back to the plain base time.
   function automatic int unsigned busy_span(input int unsigned base,
                                             input int unsigned os,
                                             input int unsigned os_max);
      if (os > os_max) return base;
      return base << os;
   endfunction

endpackage

// File: rtl/adc8_edge_det.sv
module adc8_edge_det #(
   parameter int WIDTH     = 1,
   parameter bit RISING    = 1'b1,
   parameter bit IDLE_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sig,
   output logic [WIDTH-1:0] hit
);

   logic [WIDTH-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= {WIDTH{IDLE_HIGH}};
      else        prev <= sig;
   end

   generate
      if (RISING) begin : g_rise
         assign hit = sig & ~prev;
      end else begin : g_fall
         assign hit = ~sig & prev;
      end
   endgenerate

endmodule

// File: rtl/adc8_conv_ctrl.sv
module adc8_conv_ctrl
   import adc8_pkg::*;
#(
   parameter int CH_COUNT    = 8,
   parameter int SAMPLE_W    = 16,
   parameter int BASE_CYCLES = 4,
   parameter int OS_W        = 3,
   parameter int OS_MAX      = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         dev_rst,
   input  logic                         start,
   input  logic [OS_W-1:0]              os_sel,
   output logic                         busy,
   output logic [CH_COUNT*SAMPLE_W-1:0] snap
);

   localparam int CH_W  = $clog2(CH_COUNT);
   localparam int K_W   = SAMPLE_W - CH_W;
   localparam int CNT_W = $clog2(BASE_CYCLES << OS_MAX) + 1;

   conv_state_e      state;
   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] span_m1;
   logic [K_W-1:0]   conv_idx;
   logic [K_W-1:0]   next_idx;
   logic             finish;

   always_comb begin
      span_m1 = CNT_W'(busy_span(BASE_CYCLES, 32'(os_sel), OS_MAX) - 1);
   end

   assign busy     = (state == CONV_RUN);
   assign finish   = busy && (remain == '0);
   assign next_idx = K_W'(conv_idx + 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= CONV_IDLE;
         remain   <= '0;
         conv_idx <= '0;
      end else if (dev_rst) begin
         state    <= CONV_IDLE;
         remain   <= '0;
         conv_idx <= '0;
      end else begin
         case (state)
            CONV_IDLE: begin
               if (start) begin
                  state  <= CONV_RUN;
                  remain <= span_m1;
               end
            end
            CONV_RUN: begin
               if (remain == '0) begin
                  state    <= CONV_IDLE;
                  conv_idx <= next_idx;
               end else begin
                  remain <= remain - 1'b1;
               end
            end
            default: state <= CONV_IDLE;
         endcase
      end
   end

   // One holding register per channel, all loaded on the same edge.
   generate
      for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
         logic [SAMPLE_W-1:0] word;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      word <= '0;
            else if (dev_rst) word <= '0;
            else if (finish)  word <= {CH_W'(c), next_idx};
         end
         assign snap[c*SAMPLE_W +: SAMPLE_W] = word;
      end
   endgenerate

endmodule

// File: rtl/adc8_par_port.sv
module adc8_par_port #(
   parameter int CH_COUNT = 8,
   parameter int SAMPLE_W = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         dev_rst,
   input  logic                         enable,
   input  logic                         cs_n,
   input  logic                         rd_fall,
   input  logic [CH_COUNT*SAMPLE_W-1:0] snap,
   output logic [SAMPLE_W-1:0]          data_out
);

   localparam int CH_W = $clog2(CH_COUNT);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(CH_COUNT - 1);

   logic [CH_W-1:0] ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         data_out <= '0;
      end else if (dev_rst || cs_n || !enable) begin
         ptr      <= '0;
         data_out <= '0;
      end else if (rd_fall) begin
         data_out <= snap[ptr*SAMPLE_W +: SAMPLE_W];
         ptr      <= (ptr == LAST_CH) ? '0 : ptr + 1'b1;
      end
   end

endmodule

// File: rtl/adc8_ser_port.sv
module adc8_ser_port #(
   parameter int CH_COUNT = 8,
   parameter int SAMPLE_W = 16,
   parameter int LANES    = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         dev_rst,
   input  logic                         enable,
   input  logic                         cs_n,
   input  logic                         cs_fall,
   input  logic                         sclk_fall,
   input  logic [CH_COUNT*SAMPLE_W-1:0] snap,
   output logic [LANES-1:0]             lanes
);

   localparam int CPL       = CH_COUNT / LANES;
   localparam int LANE_BITS = CPL * SAMPLE_W;

   logic active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        active <= 1'b0;
      else if (dev_rst || cs_n || !enable) active <= 1'b0;
      else if (cs_fall)                  active <= 1'b1;
   end

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [LANE_BITS-1:0] load_vec;
         logic [LANE_BITS-1:0] shreg;

         // Lowest channel of the lane lands in the top bits.
         for (genvar j = 0; j < CPL; j++) begin : g_pack
            assign load_vec[(CPL-1-j)*SAMPLE_W +: SAMPLE_W] =
               snap[(l*CPL+j)*SAMPLE_W +: SAMPLE_W];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               shreg <= '0;
            else if (cs_fall && enable && !dev_rst)
               shreg <= load_vec;
            else if (active && sclk_fall)
               shreg <= {shreg[LANE_BITS-2:0], 1'b0};
         end

         assign lanes[l] = active & shreg[LANE_BITS-1];
      end
   endgenerate

endmodule

// File: rtl/adc8_emulator.sv
module adc8_emulator #(
   parameter int CH_COUNT    = 8,
   parameter int SAMPLE_W    = 16,
   parameter int BASE_CYCLES = 4,
   parameter int OS_W        = 3,
   parameter int OS_MAX      = 6,
   parameter int LANES       = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dev_rst,
   input  logic                start_a_n,
   input  logic                start_b_n,
   input  logic [OS_W-1:0]     os_sel,
   input  logic                par_ser,
   input  logic                cs_n,
   input  logic                rd_n,
   input  logic                sclk,
   output logic                busy,
   output logic [SAMPLE_W-1:0] data_out,
   output logic                dout_a,
   output logic                dout_b
);

   generate
      if (LANES != 2) begin : g_bad_lanes
         $error("adc8_emulator: two serial lanes are required");
      end
      if ((CH_COUNT % LANES) != 0) begin : g_bad_split
         $error("adc8_emulator: CH_COUNT must split evenly over the lanes");
      end
      if (SAMPLE_W <= $clog2(CH_COUNT)) begin : g_bad_width
         $error("adc8_emulator: SAMPLE_W too small for the channel tag");
      end
      if (BASE_CYCLES < 1) begin : g_bad_base
         $error("adc8_emulator: BASE_CYCLES must be at least one");
      end
      if (OS_MAX >= (1 << OS_W)) begin : g_bad_os
         $error("adc8_emulator: OS_MAX does not fit in os_sel");
      end
   endgenerate

   logic [1:0]                   start_rise;
   logic [2:0]                   pin_fall;
   logic [CH_COUNT*SAMPLE_W-1:0] snap;
   logic [LANES-1:0]             lanes;

   adc8_edge_det #(.WIDTH(2), .RISING(1'b1), .IDLE_HIGH(1'b1)) u_start_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig   ({start_a_n, start_b_n}),
      .hit   (start_rise)
   );

   adc8_edge_det #(.WIDTH(3), .RISING(1'b0), .IDLE_HIGH(1'b1)) u_pin_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig   ({cs_n, rd_n, sclk}),
      .hit   (pin_fall)
   );

   adc8_conv_ctrl #(
      .CH_COUNT   (CH_COUNT),
      .SAMPLE_W   (SAMPLE_W),
      .BASE_CYCLES(BASE_CYCLES),
      .OS_W       (OS_W),
      .OS_MAX     (OS_MAX)
   ) u_conv (
      .clk     (clk),
      .rst_n   (rst_n),
      .dev_rst (dev_rst),
      .start   (|start_rise),
      .os_sel  (os_sel),
      .busy    (busy),
      .snap    (snap)
   );

   adc8_par_port #(.CH_COUNT(CH_COUNT), .SAMPLE_W(SAMPLE_W)) u_par (
      .clk      (clk),
      .rst_n    (rst_n),
      .dev_rst  (dev_rst),
      .enable   (!par_ser),
      .cs_n     (cs_n),
      .rd_fall  (pin_fall[1]),
      .snap     (snap),
      .data_out (data_out)
   );

   adc8_ser_port #(.CH_COUNT(CH_COUNT), .SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .dev_rst   (dev_rst),
      .enable    (par_ser),
      .cs_n      (cs_n),
      .cs_fall   (pin_fall[2]),
      .sclk_fall (pin_fall[0]),
      .snap      (snap),
      .lanes     (lanes)
   );

   assign dout_a = lanes[0];
   assign dout_b = lanes[1];

endmodule

// File: rtl/adc8_emulator_chk.sv
module adc8_emulator_chk #(
   parameter int BASE_CYCLES = 4,
   parameter int OS_MAX      = 6,
   parameter int OS_W        = 3,
   parameter int SAMPLE_W    = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                dev_rst,
   input logic                start_a_n,
   input logic                start_b_n,
   input logic [OS_W-1:0]     os_sel,
   input logic                par_ser,
   input logic                cs_n,
   input logic                busy,
   input logic [SAMPLE_W-1:0] data_out,
   input logic                dout_a,
   input logic                dout_b
);

   int unsigned     run_len;
   int unsigned     want_len;
   logic [OS_W-1:0] os_d;
   logic            busy_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len  <= 0;
         want_len <= 0;
         os_d     <= '0;
         busy_d   <= 1'b0;
      end else begin
         os_d    <= os_sel;
         busy_d  <= busy;
         run_len <= busy ? run_len + 1 : 0;
         if (busy && !busy_d)
            want_len <= (32'(os_d) > OS_MAX) ? BASE_CYCLES : (BASE_CYCLES << os_d);
      end
   end

   // R1: busy only rises after a start input returned high
   p_start_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (($past(start_a_n) && !$past(start_a_n, 2)) ||
                       ($past(start_b_n) && !$past(start_b_n, 2))));

   // R2, and R3: a restart inside a conversion would stretch the span
   p_busy_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(dev_rst)) |-> (run_len == want_len));

   p_bus_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || par_ser) |=> (data_out == '0));

   p_lane_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !par_ser) |=> (!dout_a && !dout_b));

   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst |=> !busy);

endmodule

bind adc8_emulator adc8_emulator_chk #(
   .BASE_CYCLES(BASE_CYCLES),
   .OS_MAX     (OS_MAX),
   .OS_W       (OS_W),
   .SAMPLE_W   (SAMPLE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dev_rst   (dev_rst),
   .start_a_n (start_a_n),
   .start_b_n (start_b_n),
   .os_sel    (os_sel),
   .par_ser   (par_ser),
   .cs_n      (cs_n),
   .busy      (busy),
   .data_out  (data_out),
   .dout_a    (dout_a),
   .dout_b    (dout_b)
);

// File: tb/adc8_emulator_bench.sv
`timescale 1ns / 1ps
module adc8_emulator_bench;

   localparam int CLK_PERIOD = 10;
   localparam int BASE       = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dev_rst = 1'b0;
   logic        start_a_n = 1'b1;
   logic        start_b_n = 1'b1;
   logic [2:0]  os_sel = 3'd0;
   logic        par_ser = 1'b0;
   logic        cs_n = 1'b1;
   logic        rd_n = 1'b1;
   logic        sclk = 1'b1;
   logic        busy;
   logic [15:0] data_out;
   logic        dout_a;
   logic        dout_b;

   int checks = 0;
   int fails  = 0;
   int conv_k = 0;
   int cyc    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc8_emulator u_adc8_emulator (
      .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst),
      .start_a_n(start_a_n), .start_b_n(start_b_n), .os_sel(os_sel),
      .par_ser(par_ser), .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk),
      .busy(busy), .data_out(data_out), .dout_a(dout_a), .dout_b(dout_b)
   );

   function automatic logic [15:0] exp_word(input int c, input int k);
      if (k == 0) return 16'h0000;
      return 16'((c << 13) | (k & 32'h1fff));
   endfunction

   function automatic int exp_span(input int os);
      if (os > 6) return BASE;
      return BASE << os;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic convert(input int os, input bit use_b, input bit extra);
      int len;
      @(negedge clk);
      os_sel = 3'(os);
      if (use_b) start_b_n = 1'b0; else start_a_n = 1'b0;
      @(negedge clk);
      start_a_n = 1'b1;
      start_b_n = 1'b1;
      @(negedge clk);
      check("R1 busy after start", 32'(busy), 1);
      len = 0;
      while (busy && len < 1000) begin
         len++;
         if (len == 1) os_sel = 3'($urandom_range(0, 7));
         if (extra && len == 2) start_a_n = 1'b0;
         if (extra && len == 3) start_a_n = 1'b1;
         @(negedge clk);
      end
      check(extra ? "R3 span with start during busy" : "R2 busy span", len, exp_span(os));
      conv_k++;
   endtask

   task automatic par_read(input int n);
      par_ser = 1'b0;
      cs_n    = 1'b0;
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         rd_n = 1'b0;
         @(negedge clk);
         check("R5 R4 parallel channel", data_out, exp_word(i, conv_k));
         check("R8 lanes quiet in parallel", {dout_a, dout_b}, 0);
         rd_n = 1'b1;
         @(negedge clk);
      end
      cs_n = 1'b1;
      @(negedge clk);
      check("R6 bus zero after cs rise", data_out, 0);
   endtask

   task automatic ser_read();
      logic [15:0] got_a [4];
      logic [15:0] got_b [4];
      par_ser = 1'b1;
      @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      for (int b = 0; b < 64; b++) begin
         got_a[b/16][15 - (b%16)] = dout_a;
         got_b[b/16][15 - (b%16)] = dout_b;
         if (b == 5) check("R8 bus zero in serial", data_out, 0);
         sclk = 1'b0;
         @(negedge clk);
         sclk = 1'b1;
         @(negedge clk);
      end
      for (int c = 0; c < 4; c++) begin
         check("R7 lane A word", got_a[c], exp_word(c, conv_k));
         check("R7 lane B word", got_b[c], exp_word(c + 4, conv_k));
      end
      cs_n = 1'b1;
      @(negedge clk);
      check("R8 lanes zero after cs rise", {dout_a, dout_b}, 0);
      par_ser = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 busy after reset", 32'(busy), 0);
      check("R10 data_out after reset", data_out, 0);
      check("R10 lanes after reset", {dout_a, dout_b}, 0);
      par_read(8);

      convert(0, 1'b0, 1'b0);
      par_read(8);
      convert(6, 1'b1, 1'b1);
      ser_read();
      convert(7, 1'b0, 1'b0);
      par_read(8);

      convert(2, 1'b1, 1'b0);
      par_read(3);
      par_read(8);

      // R9: converter reset in the middle of a conversion
      @(negedge clk);
      os_sel = 3'd3;
      start_a_n = 1'b0;
      @(negedge clk);
      start_a_n = 1'b1;
      @(negedge clk);
      check("R9 busy before abort", 32'(busy), 1);
      @(negedge clk);
      dev_rst = 1'b1;
      @(negedge clk);
      dev_rst = 1'b0;
      check("R9 busy cleared by reset", 32'(busy), 0);
      repeat (40) @(negedge clk);
      check("R9 busy stays low", 32'(busy), 0);
      conv_k = 0;
      par_read(8);
      convert(1, 1'b0, 1'b0);
      par_read(8);

      for (int it = 0; it < 14; it++) begin
         int os;
         int mode;
         os   = $urandom_range(0, 7);
         mode = $urandom_range(0, 2);
         convert(os, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
         if (mode == 0) ser_read();
         else if (mode == 1) par_read($urandom_range(1, 7));
         else par_read(8);
         par_read(1);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule